// File: doc/BRIEF.md
# Tiled View Address Generator

This unit maps a pixel coordinate inside a two-dimensional tiled container onto a 32-bit aperture address. It takes four inputs: the element format (8-bit, 16-bit, 32-bit or page), a 3-bit view orientation, and X and Y pixel coordinates. The orientation code selects which axes are mirrored and whether X and Y trade places. The format sets how many low coordinate bits are packed away and how far the resulting offset moves up. The orientation and format codes occupy the top five address bits, so a downstream translator can tell which view an access came through.

Alongside the address, the unit reports the line stride of the selected view: the byte distance between two vertically adjacent pixels as that view sees them. It also raises a flag when a coordinate lies outside the field the format allows, and in that case it forces the address to zero. With the default settings a single register stage sits behind the arithmetic, and a valid bit moves through that stage with the data.

Top module: `tile_view_addr_gen`

## Requirements
- R1: Address bits [28:27] hold the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page.
- R2: Address bits [31:29] hold the orientation code. Orientation bit 2 swaps the axes, bit 1 mirrors Y and bit 0 mirrors X.
- R3: Each format has a packing shift pair (X, Y): 8-bit uses (0,0), 16-bit uses (0,1), 32-bit uses (1,1) and page uses (6,6). The X field is 14 bits minus the X shift and the Y field is 13 bits minus the Y shift.
- R4: When X is above its field mask, or Y is above its field mask, the address is 0 and coord_err_o is 1.
- R5: Mirroring an axis XORs that coordinate with its full field mask.
- R6: Without the swap bit, the offset is (Y << X field width) + X. With the swap bit, it is (X << Y field width) + Y.
- R7: The offset is shifted left by the sum of the two packing shifts and placed in address bits [26:0], so a 32-bit access always has address bits [1:0] at zero.
- R8: With the swap bit set, the stride is 1 << (13 + X shift). Otherwise it is 1 << (14 + Y shift). The stride does not depend on whether the coordinate is in range.
- R9: Results appear one clock after in_valid is sampled high, and out_valid follows in_valid with the same latency. While in_valid is low, out_valid is 0 and the address, stride and flag keep their last values.
- R10: When rst_n is low, out_valid is 0. Leaving reset takes two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier and register load enable |
| fmt_i | input | 2 | Element format code |
| orient_i | input | 3 | View orientation code |
| x_i | input | 16 | Pixel X coordinate |
| y_i | input | 16 | Pixel Y coordinate |
| out_valid | output | 1 | Result qualifier |
| addr_o | output | 32 | Aperture address |
| stride_o | output | 32 | Line stride of the chosen view |
| coord_err_o | output | 1 | Coordinate out of range |

## Verification
Two functions can act on the same request: range rejection and the view/format tagging of the upper address bits. Rejection must override tagging, because a rejected request has to produce an all-zero word and no tag bits. The bench provokes this with out-of-range X or Y values sent under non-zero orientation codes and every non-8-bit format. It then confirms that the address is entirely zero while the stride still matches the requested view, since R8 makes the stride independent of the range check.

// File: rtl/tva_pkg.sv
`timescale 1ns/1ps
package tva_pkg;
  typedef enum logic [1:0] {
    FMT_8B   = 2'd0,
    FMT_16B  = 2'd1,
    FMT_32B  = 2'd2,
    FMT_PAGE = 2'd3
  } tva_fmt_e;

  localparam int ORI_XINV = 0;
  localparam int ORI_YINV = 1;
  localparam int ORI_FLIP = 2;
  localparam int FMT_W    = 2;
  localparam int ORI_W    = 3;
endpackage

// File: rtl/tva_fmt_geom.sv
`timescale 1ns/1ps
module tva_fmt_geom
  import tva_pkg::*;
#(
  parameter int W_BITS      = 14,
  parameter int H_BITS      = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int SH_W        = 3,
  parameter int BW          = 4,
  parameter int STR_SH_W    = 5
) (
  input  logic [FMT_W-1:0]    fmt_i,
  input  logic                flip_i,
  output logic [SH_W-1:0]     x_sh_o,
  output logic [SH_W-1:0]     y_sh_o,
  output logic [BW-1:0]       x_bits_o,
  output logic [BW-1:0]       y_bits_o,
  output logic [W_BITS-1:0]   x_mask_o,
  output logic [H_BITS-1:0]   y_mask_o,
  output logic [STR_SH_W-1:0] str_sh_o
);
  localparam logic [SH_W-1:0] PG_XS = SH_W'(SLOT_W_BITS);
  localparam logic [SH_W-1:0] PG_YS = SH_W'(SLOT_H_BITS);
  localparam logic [SH_W-1:0] SH0   = SH_W'(0);
  localparam logic [SH_W-1:0] SH1   = SH_W'(1);

  tva_fmt_e fmt_e;
  assign fmt_e = tva_fmt_e'(fmt_i);

  // packing shifts per element size
  always_comb begin
    case (fmt_e)
      FMT_8B:  begin x_sh_o = SH0;   y_sh_o = SH0;   end
      FMT_16B: begin x_sh_o = SH0;   y_sh_o = SH1;   end
      FMT_32B: begin x_sh_o = SH1;   y_sh_o = SH1;   end
      default: begin x_sh_o = PG_XS; y_sh_o = PG_YS; end
    endcase
  end

  always_comb begin
    x_bits_o = BW'(W_BITS) - BW'(x_sh_o);
    y_bits_o = BW'(H_BITS) - BW'(y_sh_o);
    x_mask_o = {W_BITS{1'b1}} >> x_sh_o;
    y_mask_o = {H_BITS{1'b1}} >> y_sh_o;
    if (flip_i) str_sh_o = STR_SH_W'(H_BITS) + STR_SH_W'(x_sh_o);
    else        str_sh_o = STR_SH_W'(W_BITS) + STR_SH_W'(y_sh_o);
  end
endmodule

// File: rtl/tva_coord_cond.sv
`timescale 1ns/1ps
module tva_coord_cond #(
  parameter int COORD_W = 16,
  parameter int W_BITS  = 14,
  parameter int H_BITS  = 13
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [W_BITS-1:0]  x_mask_i,
  input  logic [H_BITS-1:0]  y_mask_i,
  input  logic               inv_x_i,
  input  logic               inv_y_i,
  output logic [W_BITS-1:0]  x_o,
  output logic [H_BITS-1:0]  y_o,
  output logic               bad_o
);
  logic x_bad, y_bad;

  always_comb begin
    x_bad = x_i > COORD_W'(x_mask_i);
    y_bad = y_i > COORD_W'(y_mask_i);
    bad_o = x_bad | y_bad;
    // mirror across the whole field of the selected format
    x_o   = x_i[W_BITS-1:0] ^ (inv_x_i ? x_mask_i : '0);
    y_o   = y_i[H_BITS-1:0] ^ (inv_y_i ? y_mask_i : '0);
  end
endmodule

// File: rtl/tva_addr_pack.sv
`timescale 1ns/1ps
module tva_addr_pack
  import tva_pkg::*;
#(
  parameter int W_BITS = 14,
  parameter int H_BITS = 13,
  parameter int ADDR_W = 32,
  parameter int SH_W   = 3,
  parameter int BW     = 4
) (
  input  logic [W_BITS-1:0] x_i,
  input  logic [H_BITS-1:0] y_i,
  input  logic [BW-1:0]     x_bits_i,
  input  logic [BW-1:0]     y_bits_i,
  input  logic [SH_W-1:0]   x_sh_i,
  input  logic [SH_W-1:0]   y_sh_i,
  input  logic              flip_i,
  input  logic              bad_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [ORI_W-1:0]  orient_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFS_W = ADDR_W - FMT_W - ORI_W;

  logic [OFS_W-1:0] xe, ye, raw, ofs;
  logic [SH_W:0]    align;

  always_comb begin
    xe    = OFS_W'(x_i);
    ye    = OFS_W'(y_i);
    raw   = flip_i ? ((xe << y_bits_i) + ye) : ((ye << x_bits_i) + xe);
    align = {1'b0, x_sh_i} + {1'b0, y_sh_i};
    ofs   = raw << align;
    addr_o = bad_i ? '0 : {orient_i, fmt_i, ofs};
  end
endmodule

// File: rtl/tva_out_stage.sv
`timescale 1ns/1ps
module tva_out_stage #(
  parameter int ADDR_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              err_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic              err_o
);
  if (OUT_REG) begin : g_reg
    logic              vld_q;
    logic              vld_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [ADDR_W-1:0] str_q, str_n;
    logic              err_q, err_n;

    always_comb begin
      vld_n  = in_valid_i;
      addr_n = in_valid_i ? addr_i   : addr_q;
      str_n  = in_valid_i ? stride_i : str_q;
      err_n  = in_valid_i ? err_i    : err_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_n;
    end

    always_ff @(posedge clk) begin
      addr_q <= addr_n;
      str_q  <= str_n;
      err_q  <= err_n;
    end

    assign out_valid_o = vld_q;
    assign addr_o      = addr_q;
    assign stride_o    = str_q;
    assign err_o       = err_q;
  end else begin : g_comb
    assign out_valid_o = in_valid_i;
    assign addr_o      = addr_i;
    assign stride_o    = stride_i;
    assign err_o       = err_i;
  end
endmodule

// File: rtl/tile_view_addr_gen.sv
`timescale 1ns/1ps
module tile_view_addr_gen
  import tva_pkg::*;
#(
  parameter int CONT_W_BITS = 14,
  parameter int CONT_H_BITS = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16,
  parameter bit OUT_REG     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         fmt_i,
  input  logic [2:0]         orient_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic               out_valid,
  output logic [31:0]        addr_o,
  output logic [31:0]        stride_o,
  output logic               coord_err_o
);
  localparam int ADDR_W   = 32;
  localparam int SLOT_MAX = (SLOT_W_BITS > SLOT_H_BITS) ? SLOT_W_BITS : SLOT_H_BITS;
  localparam int DIM_MAX  = (CONT_W_BITS > CONT_H_BITS) ? CONT_W_BITS : CONT_H_BITS;
  localparam int SH_W     = $clog2(SLOT_MAX + 1);
  localparam int BW       = $clog2(DIM_MAX + 1);
  localparam int STR_SH_W = $clog2(ADDR_W);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe_q, rst_pipe_n;
  logic       rst_core_n;

  always_comb rst_pipe_n = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= rst_pipe_n;
  end
  assign rst_core_n = rst_pipe_q[1];

  logic                flip;
  logic [SH_W-1:0]     x_sh, y_sh;
  logic [BW-1:0]       x_bits, y_bits;
  logic [CONT_W_BITS-1:0] x_mask, x_cond;
  logic [CONT_H_BITS-1:0] y_mask, y_cond;
  logic [STR_SH_W-1:0] str_sh;
  logic                bad;
  logic [ADDR_W-1:0]   addr_d, stride_d;

  assign flip = orient_i[ORI_FLIP];

  tva_fmt_geom #(
    .W_BITS(CONT_W_BITS), .H_BITS(CONT_H_BITS),
    .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS),
    .SH_W(SH_W), .BW(BW), .STR_SH_W(STR_SH_W)
  ) u_geom (
    .fmt_i(fmt_i), .flip_i(flip),
    .x_sh_o(x_sh), .y_sh_o(y_sh),
    .x_bits_o(x_bits), .y_bits_o(y_bits),
    .x_mask_o(x_mask), .y_mask_o(y_mask),
    .str_sh_o(str_sh)
  );

  tva_coord_cond #(
    .COORD_W(COORD_W), .W_BITS(CONT_W_BITS), .H_BITS(CONT_H_BITS)
  ) u_cond (
    .x_i(x_i), .y_i(y_i),
    .x_mask_i(x_mask), .y_mask_i(y_mask),
    .inv_x_i(orient_i[ORI_XINV]), .inv_y_i(orient_i[ORI_YINV]),
    .x_o(x_cond), .y_o(y_cond), .bad_o(bad)
  );

  tva_addr_pack #(
    .W_BITS(CONT_W_BITS), .H_BITS(CONT_H_BITS),
    .ADDR_W(ADDR_W), .SH_W(SH_W), .BW(BW)
  ) u_pack (
    .x_i(x_cond), .y_i(y_cond),
    .x_bits_i(x_bits), .y_bits_i(y_bits),
    .x_sh_i(x_sh), .y_sh_i(y_sh),
    .flip_i(flip), .bad_i(bad),
    .fmt_i(fmt_i), .orient_i(orient_i),
    .addr_o(addr_d)
  );

  assign stride_d = ADDR_W'(1) << str_sh;

  tva_out_stage #(
    .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)
  ) u_out (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid_i(in_valid),
    .addr_i(addr_d), .stride_i(stride_d), .err_i(bad),
    .out_valid_o(out_valid),
    .addr_o(addr_o), .stride_o(stride_o), .err_o(coord_err_o)
  );
endmodule

// File: rtl/tva_chk.sv
`timescale 1ns/1ps
module tva_chk #(
  parameter int COORD_W = 16,
  parameter int W_BITS  = 14,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         fmt_i,
  input logic [2:0]         orient_i,
  input logic [COORD_W-1:0] x_i,
  input logic [31:0]        addr_o,
  input logic [31:0]        stride_o,
  input logic               out_valid,
  input logic               coord_err_o
);
  localparam logic [COORD_W-1:0] XMAX = COORD_W'((1 << W_BITS) - 1);

  // R10: no result qualifier while held in reset
  p_rst_idle_r10: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R4: a rejected coordinate yields an all-zero address
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && coord_err_o |-> addr_o == 32'd0);

  // R8: stride is always a single power of two
  p_stride_pow2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(stride_o) == 1);

  // R7: 32-bit accesses come out word aligned
  p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !coord_err_o && addr_o[28:27] == 2'd2 |-> addr_o[1:0] == 2'b00);

  if (OUT_REG) begin : g_reg_chk
    // R9: one-cycle latency of the qualifier
    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(addr_o) && $stable(stride_o) && $stable(coord_err_o));
    // R4: X beyond the widest field is always rejected
    p_xrange_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (x_i > XMAX) |=> coord_err_o);
    // R1 format tag, R2 view tag on every accepted request
    p_tags_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> coord_err_o ||
        (addr_o[28:27] == $past(fmt_i) && addr_o[31:29] == $past(orient_i)));
  end
endmodule

bind tile_view_addr_gen tva_chk #(
  .COORD_W(COORD_W), .W_BITS(CONT_W_BITS), .OUT_REG(OUT_REG)
) u_tva_chk (
  .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid),
  .fmt_i(fmt_i), .orient_i(orient_i), .x_i(x_i),
  .addr_o(addr_o), .stride_o(stride_o),
  .out_valid(out_valid), .coord_err_o(coord_err_o)
);

// File: tb/sim_tile_view_addr_gen.sv
`timescale 1ns/1ps
module sim_tile_view_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  fmt_i;
  logic [2:0]  orient_i;
  logic [15:0] x_i, y_i;
  logic        out_valid;
  logic [31:0] addr_o, stride_o;
  logic        coord_err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tile_view_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .fmt_i(fmt_i), .orient_i(orient_i), .x_i(x_i), .y_i(y_i),
    .out_valid(out_valid), .addr_o(addr_o), .stride_o(stride_o),
    .coord_err_o(coord_err_o)
  );

  // {fmt, orient, x, y, expected addr, expected stride, expected err}
  localparam int NV = 17;
  localparam logic [101:0] VEC [NV] = '{
    {2'd0, 3'd0, 16'h0005, 16'h0003, 32'h0000C005, 32'h00004000, 1'b0}, // R6 plain 8-bit
    {2'd1, 3'd0, 16'h0010, 16'h0002, 32'h08010020, 32'h00008000, 1'b0}, // R3 16-bit packing
    {2'd2, 3'd0, 16'h0001, 16'h0001, 32'h10008004, 32'h00008000, 1'b0}, // R7 32-bit shift
    {2'd3, 3'd0, 16'h0002, 16'h0001, 32'h18102000, 32'h00100000, 1'b0}, // R3 page
    {2'd0, 3'd1, 16'h0005, 16'h0003, 32'h2000FFFA, 32'h00004000, 1'b0}, // R5 X mirror
    {2'd0, 3'd2, 16'h0005, 16'h0003, 32'h47FF0005, 32'h00004000, 1'b0}, // R5 Y mirror
    {2'd0, 3'd4, 16'h0005, 16'h0003, 32'h8000A003, 32'h00002000, 1'b0}, // R6 swap
    {2'd0, 3'd7, 16'h0005, 16'h0003, 32'hE7FF5FFC, 32'h00002000, 1'b0}, // R2 all bits
    {2'd2, 3'd6, 16'h0100, 16'h0020, 32'hD0403F7C, 32'h00004000, 1'b0}, // R8 swapped 32-bit
    {2'd1, 3'd5, 16'h0003, 16'h0007, 32'hAFFF800E, 32'h00002000, 1'b0}, // R1 16-bit tag
    {2'd0, 3'd0, 16'h3FFF, 16'h1FFF, 32'h07FFFFFF, 32'h00004000, 1'b0}, // R4 edge, accepted
    {2'd0, 3'd0, 16'h4000, 16'h0000, 32'h00000000, 32'h00004000, 1'b1}, // R4 X over
    {2'd2, 3'd3, 16'h2000, 16'h0000, 32'h00000000, 32'h00008000, 1'b1}, // R4 tag suppressed
    {2'd1, 3'd0, 16'h0000, 16'h1000, 32'h00000000, 32'h00008000, 1'b1}, // R4 Y over 16-bit
    {2'd3, 3'd0, 16'h00FF, 16'h007F, 32'h1FFFF000, 32'h00100000, 1'b0}, // R7 page edge
    {2'd3, 3'd4, 16'h0100, 16'h0000, 32'h00000000, 32'h00080000, 1'b1}, // R8 stride on error
    {2'd2, 3'd3, 16'h1FFF, 16'h0FFF, 32'h70000000, 32'h00008000, 1'b0}  // R5 mirror to zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [101:0] v);
    fmt_i    = v[101:100];
    orient_i = v[99:97];
    x_i      = v[96:81];
    y_i      = v[80:65];
    in_valid = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 10000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; fmt_i = '0; orient_i = '0; x_i = '0; y_i = '0;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle after release", {31'd0, out_valid}, 32'd0);

    // table walk: drive at a falling edge, judge one edge later (R9)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
      chk("R1 R2 R3 R5 R6 R7 addr", addr_o, VEC[i][64:33]);
      chk("R8 stride", stride_o, VEC[i][32:1]);
      chk("R4 coord_err", {31'd0, coord_err_o}, {31'd0, VEC[i][0]});
    end

    // R9: idle request with an out-of-range coordinate changes nothing
    in_valid = 1'b0; fmt_i = 2'd0; orient_i = 3'd7; x_i = 16'hFFFF; y_i = 16'hFFFF;
    @(negedge clk);
    chk("R9 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 hold addr", addr_o, 32'h70000000);
    chk("R9 hold stride", stride_o, 32'h00008000);
    chk("R9 hold err", {31'd0, coord_err_o}, 32'd0);
    @(negedge clk);
    chk("R9 hold addr 2nd cycle", addr_o, 32'h70000000);

    // R10: reset taken mid-stream clears the qualifier at once
    drive(VEC[0]);
    @(negedge clk);
    chk("R9 resume", addr_o, 32'h0000C005);
    #5 rst_n = 1'b0;
    #2 chk("R10 async clear", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R10 held in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 release delay", {31'd0, out_valid}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 running again", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule